// File: doc/BRIEF.md
# Key-Locked Watchdog Timer with Early Warning

This block is a watchdog timer peripheral that sits on a simple 32-bit register bus. A down-counter steps once for each pulse on a slow tick input (32768 ticks make one second). Software loads a start value and, before the counter runs out, loads it again as a keepalive. If the counter reaches zero with the reset output enabled, the block raises a sticky reset request. A second programmable threshold raises an early-warning interrupt while there is still time left, so software can act before the reset.

Every register except the lock register is write-protected. Writes take effect only after the unlock key 0xE551 has been written to the lock register at offset 0x20. Any other value written there arms the protection again. Reads are always allowed. A reload is not instant. Writing the load-low register starts a three-state sequence: IDLE goes to ARMED on the load write, ARMED goes to STAGED on the next tick, and STAGED goes back to IDLE on the following tick. On that last step the new value is copied into the counter. A busy status flag is set whenever the sequence is not in IDLE.

The counter has two interrupt modes, chosen by control bit 2. With the bit set, the early-warning interrupt fires at the programmed threshold. With the bit clear, the interrupt fires together with expiry.

Top module: `kwdog_top`

## Requirements
- R1: After reset the block is locked, the control, mask, count and status registers read 0, and both wdt_irq and wdt_rst_req are low.
- R2: A write to any offset other than 0x20 has no effect unless the last value written to offset 0x20 was 0xE551. Writing any other value to 0x20 locks the block again. Reading 0x20 returns 1 in bit 0 while the block is unlocked. Reads are always allowed.
- R3: Register offsets are: load low 0x00, load high 0x04, control 0x08, clear 0x0C, status 0x10, mask 0x14, count low 0x18, count high 0x1C, lock 0x20, threshold low 0x2C, threshold high 0x30. Each 32-bit value is split into bits [15:0] of the low register and bits [31:16] held in bits [15:0] of the high register. Upper bits of these registers read 0.
- R4: A write to load low (0x00) stores bits [15:0] and starts a reload. From the next cycle, status bit 4 (busy) reads 1. On the second tick after the write, the count becomes {load high, load low} and busy returns to 0.
- R5: A write to load low while busy is set is ignored. It changes neither the stored value nor the reload.
- R6: With control bit 1 set, the count drops by exactly one on each tick that does not commit a reload. With bit 1 clear the count holds. A count of zero stays at zero.
- R7: With control bit 2 set, status bit 0 is set on the tick where the count steps down to {threshold high, threshold low}.
- R8: With control bit 2 clear, reaching the threshold does not set status bit 0. Instead, the bit is set on the tick where the count steps from 1 to 0.
- R9: wdt_irq is high exactly when status bit 0, control bit 0 and NOT mask bit 0 are all true.
- R10: When the count steps from 1 to 0 with control bit 3 set, status bit 3 and wdt_rst_req become 1 and stay 1. With control bit 3 clear, expiry does not raise them.
- R11: An unlocked write to the clear register (0x0C) clears status bit 0 when data bit 0 is 1, and clears status bit 3 (and wdt_rst_req) when data bit 3 is 1.
- R12: A reload while the counter is running restores the count to the load value, and this prevents the expiry that would otherwise have come.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and logic clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slow_tick | input | 1 | One-cycle pulse per counter step (32768 per second) |
| bus_wr | input | 1 | Write strobe, single cycle |
| bus_rd | input | 1 | Read strobe; read data is 0 when low |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| wdt_irq | output | 1 | Early-warning interrupt |
| wdt_rst_req | output | 1 | Sticky reset request |

## Verification
A reload sequence stuck outside IDLE would leave busy reading 1 from the status register, and later load writes would be silently dropped. A missed commit shows up two ticks after a load write, as a count that does not match the load value. An off-by-one in the threshold compare moves the first rise of wdt_irq by one tick, so the bench samples the interrupt on the tick just before the expected one and on the expected tick itself. A lock flag that is wrong appears at the next protected write, which either changes a register it should not or fails to change one it should.

// File: rtl/kwdog_pkg.sv
package kwdog_pkg;

    // Register byte offsets; software depends on these values.
    localparam logic [5:0] A_LOAD_LO = 6'h00;
    localparam logic [5:0] A_LOAD_HI = 6'h04;
    localparam logic [5:0] A_CTRL    = 6'h08;
    localparam logic [5:0] A_CLEAR   = 6'h0C;
    localparam logic [5:0] A_STATUS  = 6'h10;
    localparam logic [5:0] A_MASK    = 6'h14;
    localparam logic [5:0] A_CNT_LO  = 6'h18;
    localparam logic [5:0] A_CNT_HI  = 6'h1C;
    localparam logic [5:0] A_LOCK    = 6'h20;
    localparam logic [5:0] A_PRE_LO  = 6'h2C;
    localparam logic [5:0] A_PRE_HI  = 6'h30;

    // Control register layout, bit 3 down to bit 0.
    typedef struct packed {
        logic rst_en;    // bit 3
        logic pre_mode;  // bit 2
        logic cnt_en;    // bit 1
        logic int_en;    // bit 0
    } ctrl_t;

    // Reload sequence states.
    typedef enum logic [1:0] {
        RL_IDLE   = 2'd0,
        RL_ARMED  = 2'd1,
        RL_STAGED = 2'd2
    } reload_state_t;

endpackage

// File: rtl/kwdog_reload.sv
module kwdog_reload (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic kick,
    output logic busy,
    output logic commit
);
    import kwdog_pkg::*;

    reload_state_t state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RL_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            RL_IDLE:   if (kick) state_nx = RL_ARMED;
            RL_ARMED:  if (tick) state_nx = RL_STAGED;
            RL_STAGED: if (tick) state_nx = RL_IDLE;
            default:   state_nx = RL_IDLE;
        endcase
    end

    always_comb begin
        busy   = 1'b0;
        commit = 1'b0;
        unique case (state)
            RL_IDLE:   busy = 1'b0;
            RL_ARMED:  busy = 1'b1;
            RL_STAGED: begin
                busy   = 1'b1;
                commit = tick;
            end
            default:   busy = 1'b0;
        endcase
    end

    // R4: a load accepted in IDLE makes busy visible on the next cycle
    p_kick_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (kick && state == RL_IDLE) |=> busy);

    // R4: the first tick after arming moves to the staged state
    p_arm_stage_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RL_ARMED && tick) |=> (state == RL_STAGED));

    // R4: a commit always ends the busy window
    p_commit_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !busy);

endmodule

// File: rtl/kwdog_counter.sv
module kwdog_counter #(
    parameter int HALF_W = 16,
    localparam int CNT_W = 2 * HALF_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             cnt_en,
    input  logic             pre_mode,
    input  logic             rst_en,
    input  logic             commit,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] pre_val,
    input  logic             clr_int,
    input  logic             clr_rst,
    output logic [CNT_W-1:0] count,
    output logic             int_raw,
    output logic             rst_raw
);
    logic             step;
    logic             expire;
    logic             pre_hit;
    logic [CNT_W-1:0] count_dec;

    assign count_dec = count - CNT_W'(1);
    assign step      = tick && cnt_en && (count != '0) && !commit;
    assign expire    = step && (count == CNT_W'(1));
    assign pre_hit   = pre_mode ? (count_dec == pre_val) : (count == CNT_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      count <= '0;
        else if (commit) count <= load_val;
        else if (step)   count <= count_dec;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                int_raw <= 1'b0;
        else if (step && pre_hit)  int_raw <= 1'b1;
        else if (clr_int)          int_raw <= 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                rst_raw <= 1'b0;
        else if (expire && rst_en) rst_raw <= 1'b1;
        else if (clr_rst)          rst_raw <= 1'b0;
    end

    // R6: a tick with the counter enabled removes exactly one step
    p_step_one_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cnt_en && count != '0 && !commit) |=> (count == $past(count) - CNT_W'(1)));

    // R6: zero is a floor
    p_zero_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0 && !commit) |=> (count == '0));

    // R4: a commit copies the load value
    p_commit_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (count == $past(load_val)));

    // R10: the reset event stays until cleared
    p_rst_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_raw && !clr_rst) |=> rst_raw);

endmodule

// File: rtl/kwdog_regs.sv
module kwdog_regs #(
    parameter int           HALF_W = 16,
    parameter int           ADDR_W = 6,
    parameter int           DATA_W = 32,
    parameter logic [15:0]  KEY    = 16'hE551,
    localparam int          CNT_W  = 2 * HALF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              busy,
    input  logic [CNT_W-1:0]  count,
    input  logic              int_raw,
    input  logic              rst_raw,
    output kwdog_pkg::ctrl_t  ctrl,
    output logic              mask,
    output logic [CNT_W-1:0]  load_val,
    output logic [CNT_W-1:0]  pre_val,
    output logic              kick,
    output logic              clr_int,
    output logic              clr_rst
);
    import kwdog_pkg::*;

    logic              unlocked;
    logic              wr_ok;
    logic [HALF_W-1:0] ld_lo, ld_hi, pre_lo, pre_hi;
    logic [5:0]        addr6;

    assign addr6 = 6'(bus_addr);
    assign wr_ok = bus_wr && (unlocked || addr6 == A_LOCK);
    assign kick  = wr_ok && (addr6 == A_LOAD_LO) && !busy;

    assign clr_int = wr_ok && (addr6 == A_CLEAR) && bus_wdata[0];
    assign clr_rst = wr_ok && (addr6 == A_CLEAR) && bus_wdata[3];

    assign load_val = {ld_hi, ld_lo};
    assign pre_val  = {pre_hi, pre_lo};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            unlocked <= 1'b0;
            ctrl     <= '0;
            mask     <= 1'b0;
            ld_lo    <= '0;
            ld_hi    <= '0;
            pre_lo   <= '0;
            pre_hi   <= '0;
        end else if (wr_ok) begin
            unique case (addr6)
                A_LOCK:    unlocked <= (bus_wdata == DATA_W'(KEY));
                A_LOAD_LO: if (!busy) ld_lo <= bus_wdata[HALF_W-1:0];
                A_LOAD_HI: ld_hi  <= bus_wdata[HALF_W-1:0];
                A_PRE_LO:  pre_lo <= bus_wdata[HALF_W-1:0];
                A_PRE_HI:  pre_hi <= bus_wdata[HALF_W-1:0];
                A_CTRL:    ctrl   <= ctrl_t'(bus_wdata[3:0]);
                A_MASK:    mask   <= bus_wdata[0];
                default:   ;
            endcase
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            unique case (addr6)
                A_LOAD_LO: bus_rdata = DATA_W'(ld_lo);
                A_LOAD_HI: bus_rdata = DATA_W'(ld_hi);
                A_PRE_LO:  bus_rdata = DATA_W'(pre_lo);
                A_PRE_HI:  bus_rdata = DATA_W'(pre_hi);
                A_CTRL:    bus_rdata = DATA_W'(ctrl);
                A_MASK:    bus_rdata = DATA_W'(mask);
                A_STATUS:  bus_rdata = DATA_W'({busy, rst_raw, 2'b00, int_raw});
                A_CNT_LO:  bus_rdata = DATA_W'(count[HALF_W-1:0]);
                A_CNT_HI:  bus_rdata = DATA_W'(count[CNT_W-1:HALF_W]);
                A_LOCK:    bus_rdata = DATA_W'(unlocked);
                default:   bus_rdata = '0;
            endcase
        end
    end

    // R2: while locked, the control register cannot change
    p_locked_ctrl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !unlocked |=> $stable(ctrl));

    // R2: while locked, the threshold cannot change
    p_locked_pre_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !unlocked |=> $stable(pre_val));

    // R5: a load write during a reload leaves the stored value alone
    p_busy_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && bus_wr && addr6 == A_LOAD_LO) |=> $stable(ld_lo));

endmodule

// File: rtl/kwdog_top.sv
module kwdog_top #(
    parameter int          HALF_W = 16,
    parameter int          ADDR_W = 6,
    parameter int          DATA_W = 32,
    parameter logic [15:0] KEY    = 16'hE551
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slow_tick,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              wdt_irq,
    output logic              wdt_rst_req
);
    import kwdog_pkg::*;

    localparam int CNT_W = 2 * HALF_W;

    ctrl_t            ctrl;
    logic             mask;
    logic [CNT_W-1:0] load_val, pre_val, count;
    logic             kick, clr_int, clr_rst;
    logic             busy, commit;
    logic             int_raw, rst_raw;

    kwdog_regs #(
        .HALF_W (HALF_W),
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .KEY    (KEY)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .busy      (busy),
        .count     (count),
        .int_raw   (int_raw),
        .rst_raw   (rst_raw),
        .ctrl      (ctrl),
        .mask      (mask),
        .load_val  (load_val),
        .pre_val   (pre_val),
        .kick      (kick),
        .clr_int   (clr_int),
        .clr_rst   (clr_rst)
    );

    kwdog_reload u_reload (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (slow_tick),
        .kick   (kick),
        .busy   (busy),
        .commit (commit)
    );

    kwdog_counter #(
        .HALF_W (HALF_W)
    ) u_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (slow_tick),
        .cnt_en   (ctrl.cnt_en),
        .pre_mode (ctrl.pre_mode),
        .rst_en   (ctrl.rst_en),
        .commit   (commit),
        .load_val (load_val),
        .pre_val  (pre_val),
        .clr_int  (clr_int),
        .clr_rst  (clr_rst),
        .count    (count),
        .int_raw  (int_raw),
        .rst_raw  (rst_raw)
    );

    assign wdt_irq     = int_raw && ctrl.int_en && !mask;
    assign wdt_rst_req = rst_raw;

    // R10: the reset request never drops without a clear
    p_req_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wdt_rst_req && !clr_rst) |=> wdt_rst_req);

endmodule

// File: tb/kwdog_top_tb.sv
module kwdog_top_tb;

    localparam logic [5:0] T_LDLO = 6'h00, T_LDHI = 6'h04, T_CTRL = 6'h08,
                           T_CLR  = 6'h0C, T_STAT = 6'h10, T_MASK = 6'h14,
                           T_CNLO = 6'h18, T_CNHI = 6'h1C, T_LOCK = 6'h20,
                           T_PRLO = 6'h2C, T_PRHI = 6'h30;

    // {address, write data, expected read-back}
    localparam int NV = 6;
    localparam logic [95:0] VEC [NV] = '{
        {32'h04, 32'hABCD1234, 32'h00001234},
        {32'h2C, 32'h00017777, 32'h00007777},
        {32'h30, 32'hFFFF0002, 32'h00000002},
        {32'h14, 32'hFFFFFFFF, 32'h00000001},
        {32'h08, 32'hFFFFFFF0, 32'h00000000},
        {32'h08, 32'h00000005, 32'h00000005}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        slow_tick = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        wdt_irq, wdt_rst_req;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    kwdog_top u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .slow_tick   (slow_tick),
        .bus_wr      (bus_wr),
        .bus_rd      (bus_rd),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .wdt_irq     (wdt_irq),
        .wdt_rst_req (wdt_rst_req)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        bus_rd = 1'b1; bus_addr = a;
        #1;
        d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic tk(input int n);
        for (int i = 0; i < n; i++) begin
            slow_tick = 1'b1;
            @(posedge clk);
            @(negedge clk);
            slow_tick = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic chk_rd(input string req, input logic [5:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        check(req, v, exp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 irq", {31'b0, wdt_irq}, 32'h0);
        check("R1 rst_req", {31'b0, wdt_rst_req}, 32'h0);
        chk_rd("R1 status", T_STAT, 32'h0);
        chk_rd("R1 count", T_CNLO, 32'h0);
        chk_rd("R1 lock", T_LOCK, 32'h0);

        // R2 locked write ignored
        wr(T_CTRL, 32'hF);
        chk_rd("R2 locked ctrl", T_CTRL, 32'h0);
        wr(T_LOCK, 32'h0000E551);
        chk_rd("R2 unlocked", T_LOCK, 32'h1);

        // R3 table walk
        for (int i = 0; i < NV; i++) begin
            wr(VEC[i][69:64], VEC[i][63:32]);
            chk_rd("R3 readback", VEC[i][69:64], VEC[i][31:0]);
        end

        wr(T_CTRL, 32'h0);
        wr(T_MASK, 32'h0);
        wr(T_LDHI, 32'h0);
        wr(T_PRHI, 32'h0);
        wr(T_PRLO, 32'h3);

        // R4 reload with busy window, R5 ignore during busy
        wr(T_LDLO, 32'd10);
        chk_rd("R4 busy set", T_STAT, 32'h10);
        wr(T_LDLO, 32'd99);
        chk_rd("R5 load kept", T_LDLO, 32'd10);
        tk(1);
        chk_rd("R4 still busy", T_STAT, 32'h10);
        tk(1);
        chk_rd("R4 busy clear", T_STAT, 32'h0);
        chk_rd("R4 count loaded", T_CNLO, 32'd10);
        tk(1);
        chk_rd("R6 hold when disabled", T_CNLO, 32'd10);

        // R7 threshold interrupt
        wr(T_CTRL, 32'hF);
        tk(6);
        chk_rd("R6 count after 6", T_CNLO, 32'd4);
        check("R7 irq before threshold", {31'b0, wdt_irq}, 32'h0);
        tk(1);
        check("R7 irq at threshold", {31'b0, wdt_irq}, 32'h1);
        chk_rd("R7 status", T_STAT, 32'h1);
        wr(T_MASK, 32'h1);
        check("R9 masked irq", {31'b0, wdt_irq}, 32'h0);
        chk_rd("R9 raw kept", T_STAT, 32'h1);
        wr(T_MASK, 32'h0);
        check("R9 unmasked irq", {31'b0, wdt_irq}, 32'h1);
        wr(T_CLR, 32'h1);
        check("R11 irq cleared", {31'b0, wdt_irq}, 32'h0);
        chk_rd("R11 status cleared", T_STAT, 32'h0);

        // R12 keepalive
        wr(T_LDLO, 32'd10);
        tk(2);
        chk_rd("R12 kick count", T_CNLO, 32'd10);
        check("R12 no reset", {31'b0, wdt_rst_req}, 32'h0);

        // R10 expiry
        tk(9);
        check("R10 not yet", {31'b0, wdt_rst_req}, 32'h0);
        tk(1);
        check("R10 reset req", {31'b0, wdt_rst_req}, 32'h1);
        chk_rd("R10 status", T_STAT, 32'h9);
        tk(2);
        chk_rd("R6 zero floor", T_CNLO, 32'h0);
        check("R10 sticky", {31'b0, wdt_rst_req}, 32'h1);

        // R2 relock; R11 reset clear
        wr(T_LOCK, 32'h0);
        wr(T_CLR, 32'h8);
        check("R2 locked clear", {31'b0, wdt_rst_req}, 32'h1);
        chk_rd("R2 relocked", T_LOCK, 32'h0);
        wr(T_LOCK, 32'h0000E551);
        wr(T_CLR, 32'h8);
        check("R11 reset cleared", {31'b0, wdt_rst_req}, 32'h0);
        wr(T_CLR, 32'h1);

        // R8 expiry-mode interrupt
        wr(T_CTRL, 32'h3);
        wr(T_LDLO, 32'd5);
        tk(2);
        chk_rd("R8 loaded", T_CNLO, 32'd5);
        tk(2);
        chk_rd("R8 no threshold irq", T_STAT, 32'h0);
        tk(2);
        check("R8 not yet", {31'b0, wdt_irq}, 32'h0);
        tk(1);
        check("R8 irq at expiry", {31'b0, wdt_irq}, 32'h1);
        check("R10 no reset when disabled", {31'b0, wdt_rst_req}, 32'h0);

        // R3 split halves and borrow
        wr(T_LDHI, 32'h1);
        wr(T_LDLO, 32'h2);
        tk(2);
        chk_rd("R3 cnt lo", T_CNLO, 32'h2);
        chk_rd("R3 cnt hi", T_CNHI, 32'h1);
        tk(2);
        chk_rd("R6 lo at boundary", T_CNLO, 32'h0);
        tk(1);
        chk_rd("R6 borrow lo", T_CNLO, 32'hFFFF);
        chk_rd("R6 borrow hi", T_CNHI, 32'h0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule